// File: doc/BRIEF.md
# Lockable IO Delay Register Bank

This block is the register side of an IO delay controller. It holds the calibration results for the delay lines as read-only words, a global key register that opens or closes the per-pin region, and three 32-bit configuration words per pin. Software first opens the region with the unlock key. It then writes each pin's configuration word, which must carry the correct signature. The coarse and fine element counts from the first word of every pin drive the delay lines directly.

Access goes through a request/response port with valid/ready on both sides. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The bank holds one transaction at a time, so `req_ready` is low while a response is waiting. The response appears the cycle after the request is taken and stays unchanged, with `rsp_valid` high, until the cycle in which `rsp_ready` is high. Addresses are byte offsets of 32-bit words.

Top module: `iodly_regbank`

## Requirements
- R1: After reset the global key register reads 0x0000AAAB (locked), every per-pin word reads zero, and all `pin_coarse` and `pin_fine` outputs are zero.
- R2: The calibration words are captured from the `cal_*` inputs on every clock edge while `rst_n` is low. Offset 0x14 reads {16'h0, period}, 0x18 reads {coarse delay count, coarse reference count} and 0x1C reads {fine delay count, fine reference count}, with the delay count in bits 31:16. Bus writes to these offsets and input changes after reset leave them unchanged.
- R3: A write to offset 0x2C with low 16 bits 0xAAAA opens the region, 0xAAAB closes it, and any other value leaves the state as it was. The register reads 0x0000AAAA when open and 0x0000AAAB when closed.
- R4: The per-pin word for pin p and word r (r = 0..2) is at offset 0x30 + 12p + 4r, up to 0xD1C for the default 276 pins. The word keeps bits 17:12 (signature), 10 (lock), 9:5 (coarse) and 4:0 (fine), and all other bits read as zero.
- R5: A per-pin write takes effect only while the region is open and only when bits 17:12 of the written data equal 0x29. Otherwise the stored word is unchanged.
- R6: If the stored lock bit (bit 10) is 1 and the written data also has bit 10 set, the write is ignored. A write whose bit 10 is 0 is accepted, subject to R5.
- R7: `pin_coarse[5p +: 5]` and `pin_fine[5p +: 5]` show the coarse and fine fields of word 0 of pin p. They change on the clock edge that takes the write. Words 1 and 2 do not affect them.
- R8: An access to an offset above the last per-pin word, or with address bits 1:0 not zero, returns `rsp_err` = 1 and read data zero, and has no effect on any register. Unused offsets in range (0x00–0x10, 0x20–0x28) read zero with `rsp_err` = 0.
- R9: `req_ready` is high exactly when no response is pending. The response to a taken request is valid from the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; calibration capture while low |
| cal_refclk_period | input | 16 | Reference clock period from calibration |
| cal_coarse_delay | input | 16 | Coarse delay count |
| cal_coarse_ref | input | 16 | Coarse reference count |
| cal_fine_delay | input | 16 | Fine delay count |
| cal_fine_ref | input | 16 | Fine reference count |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Bad offset or misaligned access |
| pin_coarse | output | 5*NUM_PINS (1380) | Coarse element count per pin, from word 0 |
| pin_fine | output | 5*NUM_PINS (1380) | Fine element count per pin, from word 0 |

## Verification
The bench attacks the write-gating corners. It writes with the region closed and after re-closing it, writes with a signature off by one, and re-writes a locked word with and without clearing its lock bit; a design with a loose gate would show the new value on read-back. It aims at the region edges: the last valid word at 0xD1C is written, 0xD20 and a misaligned offset must report an error without touching the word they alias, and writes to word 1 must leave the pin's outputs alone. It also holds off `rsp_ready` to catch a response that changes or is dropped under back-pressure. Finally, it changes the calibration inputs after reset to catch capture logic that keeps tracking them.

// File: rtl/iodly_pkg.sv
package iodly_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned OFS_REFCLK = 'h014;
  localparam int unsigned OFS_CRS    = 'h018;
  localparam int unsigned OFS_FIN    = 'h01C;
  localparam int unsigned OFS_GLOCK  = 'h02C;
  localparam int unsigned OFS_PIN0   = 'h030;

  localparam logic [15:0] KEY_OPEN = 16'hAAAA;
  localparam logic [15:0] KEY_SHUT = 16'hAAAB;

  localparam int unsigned SIG_W   = 6;
  localparam int unsigned CRS_W   = 5;
  localparam int unsigned FIN_W   = 5;
  localparam int unsigned SIG_LSB = 12;
  localparam int unsigned LOCK_B  = 10;
  localparam int unsigned CRS_LSB = 5;
  localparam int unsigned FIN_LSB = 0;
  localparam logic [SIG_W-1:0] SIG_OK = 6'h29;

  typedef struct packed {
    logic [SIG_W-1:0] sig;
    logic             lock;
    logic [CRS_W-1:0] crs;
    logic [FIN_W-1:0] fin;
  } pin_word_t;

  typedef enum logic [2:0] {
    RG_REFCLK, RG_CRS, RG_FIN, RG_GLOCK, RG_PIN, RG_RSVD, RG_BAD
  } region_e;

  function automatic logic [DATA_W-1:0] word_pack(input pin_word_t w);
    logic [DATA_W-1:0] r;
    r = '0;
    r[SIG_LSB +: SIG_W] = w.sig;
    r[LOCK_B]           = w.lock;
    r[CRS_LSB +: CRS_W] = w.crs;
    r[FIN_LSB +: FIN_W] = w.fin;
    return r;
  endfunction

  function automatic pin_word_t word_unpack(input logic [DATA_W-1:0] d);
    pin_word_t w;
    w.sig  = d[SIG_LSB +: SIG_W];
    w.lock = d[LOCK_B];
    w.crs  = d[CRS_LSB +: CRS_W];
    w.fin  = d[FIN_LSB +: FIN_W];
    return w;
  endfunction

endpackage

// File: rtl/iodly_decode.sv
module iodly_decode
  import iodly_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_ENTRIES = 828,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned LAST_OFS = OFS_PIN0 + 4 * NUM_ENTRIES - 4;

  logic [31:0]       addr_ext;
  logic [ADDR_W-1:0] rel;
  logic              unused_rel;

  assign addr_ext   = 32'(addr);
  assign rel        = addr - ADDR_W'(OFS_PIN0);
  assign idx        = rel[IDX_W+1:2];
  assign unused_rel = ^{rel[1:0], rel[ADDR_W-1:IDX_W+2]};

  always_comb begin
    if (addr[1:0] != 2'b00 || addr_ext > LAST_OFS) begin
      region = RG_BAD;
    end else if (addr_ext == OFS_REFCLK) begin
      region = RG_REFCLK;
    end else if (addr_ext == OFS_CRS) begin
      region = RG_CRS;
    end else if (addr_ext == OFS_FIN) begin
      region = RG_FIN;
    end else if (addr_ext == OFS_GLOCK) begin
      region = RG_GLOCK;
    end else if (addr_ext >= OFS_PIN0) begin
      region = RG_PIN;
    end else begin
      region = RG_RSVD;
    end
  end

  always_comb begin
    if (region == RG_PIN) begin
      AST_PIN_IDX_RANGE: assert (32'(idx) < NUM_ENTRIES); // R4
    end
  end

endmodule

// File: rtl/iodly_cal.sv
module iodly_cal
  import iodly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       period,
  input  logic [15:0]       crs_delay,
  input  logic [15:0]       crs_ref,
  input  logic [15:0]       fin_delay,
  input  logic [15:0]       fin_ref,
  output logic [DATA_W-1:0] word_refclk,
  output logic [DATA_W-1:0] word_crs,
  output logic [DATA_W-1:0] word_fin
);

  logic [15:0] period_q, crs_delay_q, crs_ref_q, fin_delay_q, fin_ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q    <= period;
      crs_delay_q <= crs_delay;
      crs_ref_q   <= crs_ref;
      fin_delay_q <= fin_delay;
      fin_ref_q   <= fin_ref;
    end
  end

  assign word_refclk = {16'h0000, period_q};
  assign word_crs    = {crs_delay_q, crs_ref_q};
  assign word_fin    = {fin_delay_q, fin_ref_q};

  AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(word_refclk) && $stable(word_crs) && $stable(word_fin)); // R2

endmodule

// File: rtl/iodly_glock.sv
module iodly_glock
  import iodly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wkey,
  output logic              open,
  output logic [DATA_W-1:0] rd_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open <= 1'b0;
    end else if (wr_en) begin
      if (wkey == KEY_OPEN) begin
        open <= 1'b1;
      end else if (wkey == KEY_SHUT) begin
        open <= 1'b0;
      end
    end
  end

  assign rd_word = {16'h0000, open ? KEY_OPEN : KEY_SHUT};

  AST_KEY_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wkey == KEY_OPEN || wkey == KEY_SHUT)) |=> $stable(open)); // R3

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wkey == KEY_OPEN |=> rd_word[15:0] == KEY_OPEN); // R3

endmodule

// File: rtl/iodly_pin_bank.sv
module iodly_pin_bank
  import iodly_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 276,
  parameter int unsigned REGS_PER_PIN = 3,
  localparam int unsigned NUM_ENTRIES = NUM_PINS * REGS_PER_PIN,
  localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          idx,
  input  pin_word_t                 wnew,
  input  logic                      region_open,
  output pin_word_t                 rd_word,
  output logic [NUM_PINS*CRS_W-1:0] pin_coarse,
  output logic [NUM_PINS*FIN_W-1:0] pin_fine
);

  pin_word_t store [NUM_ENTRIES];
  pin_word_t cur;
  logic      sig_good;
  logic      lock_block;
  logic      take;

  assign cur        = store[idx];
  assign sig_good   = (wnew.sig == SIG_OK);
  assign lock_block = cur.lock && wnew.lock;
  assign take       = wr_en && region_open && sig_good && !lock_block;
  assign rd_word    = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(NUM_ENTRIES); k++) begin
        store[k] <= '0;
      end
    end else if (take) begin
      store[idx] <= wnew;
    end
  end

  for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin_out
    assign pin_coarse[p*CRS_W +: CRS_W] = store[p*REGS_PER_PIN].crs;
    assign pin_fine[p*FIN_W +: FIN_W]   = store[p*REGS_PER_PIN].fin;
  end

  AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !region_open |=> store[$past(idx)] == $past(cur)); // R5

  AST_BADSIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wnew.sig != SIG_OK |=> store[$past(idx)] == $past(cur)); // R5

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cur.lock && wnew.lock |=> store[$past(idx)] == $past(cur)); // R6

  AST_GOOD_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && region_open && wnew.sig == SIG_OK && !wnew.lock
      |=> store[$past(idx)] == $past(wnew)); // R6

endmodule

// File: rtl/iodly_regbank.sv
module iodly_regbank
  import iodly_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned NUM_PINS     = 276,
  parameter int unsigned REGS_PER_PIN = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [15:0]               cal_refclk_period,
  input  logic [15:0]               cal_coarse_delay,
  input  logic [15:0]               cal_coarse_ref,
  input  logic [15:0]               cal_fine_delay,
  input  logic [15:0]               cal_fine_ref,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err,
  output logic [NUM_PINS*CRS_W-1:0] pin_coarse,
  output logic [NUM_PINS*FIN_W-1:0] pin_fine
);

  localparam int unsigned NUM_ENTRIES = NUM_PINS * REGS_PER_PIN;
  localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES);

  region_e           region;
  logic [IDX_W-1:0]  idx;
  logic              hs;
  logic              wr_hs;
  logic [DATA_W-1:0] w_refclk, w_crs, w_fin, w_glock;
  logic              region_open;
  pin_word_t         pin_rd;
  pin_word_t         pin_new;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign req_ready    = !rsp_valid;
  assign hs           = req_valid && req_ready;
  assign wr_hs        = hs && req_write;
  assign pin_new      = word_unpack(req_wdata);
  assign unused_wbits = ^{req_wdata[DATA_W-1:SIG_LSB+SIG_W], req_wdata[LOCK_B+1]};

  iodly_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_ENTRIES (NUM_ENTRIES)
  ) i_decode (
    .addr   (req_addr),
    .region (region),
    .idx    (idx)
  );

  iodly_cal i_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .period      (cal_refclk_period),
    .crs_delay   (cal_coarse_delay),
    .crs_ref     (cal_coarse_ref),
    .fin_delay   (cal_fine_delay),
    .fin_ref     (cal_fine_ref),
    .word_refclk (w_refclk),
    .word_crs    (w_crs),
    .word_fin    (w_fin)
  );

  iodly_glock i_glock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hs && region == RG_GLOCK),
    .wkey    (req_wdata[15:0]),
    .open    (region_open),
    .rd_word (w_glock)
  );

  iodly_pin_bank #(
    .NUM_PINS     (NUM_PINS),
    .REGS_PER_PIN (REGS_PER_PIN)
  ) i_pin_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_hs && region == RG_PIN),
    .idx         (idx),
    .wnew        (pin_new),
    .region_open (region_open),
    .rd_word     (pin_rd),
    .pin_coarse  (pin_coarse),
    .pin_fine    (pin_fine)
  );

  always_comb begin
    unique case (region)
      RG_REFCLK: rd_mux = w_refclk;
      RG_CRS:    rd_mux = w_crs;
      RG_FIN:    rd_mux = w_fin;
      RG_GLOCK:  rd_mux = w_glock;
      RG_PIN:    rd_mux = word_pack(pin_rd);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (hs) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
      rsp_err   <= (region == RG_BAD);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R9

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0); // R8

endmodule

// File: tb/test_iodly_regbank.sv
module test_iodly_regbank;

  localparam int NPINS = 276;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cal_refclk_period = 16'h0A5C;
  logic [15:0] cal_coarse_delay  = 16'h0123;
  logic [15:0] cal_coarse_ref    = 16'h0456;
  logic [15:0] cal_fine_delay    = 16'h0789;
  logic [15:0] cal_fine_ref      = 16'h0ABC;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [NPINS*5-1:0] pin_coarse;
  logic [NPINS*5-1:0] pin_fine;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  iodly_regbank i_iodly_regbank (
    .clk(clk), .rst_n(rst_n),
    .cal_refclk_period(cal_refclk_period), .cal_coarse_delay(cal_coarse_delay),
    .cal_coarse_ref(cal_coarse_ref), .cal_fine_delay(cal_fine_delay),
    .cal_fine_ref(cal_fine_ref),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .pin_coarse(pin_coarse), .pin_fine(pin_fine)
  );

  function automatic logic [31:0] mk(input logic [5:0] sig, input logic lk,
                                     input logic [4:0] c, input logic [4:0] f);
    return {14'h0, sig, 1'b0, lk, c, f};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid after request", {31'h0, rsp_valid}, 32'h1);
    rd = rsp_rdata; er = rsp_err;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    xfer(1'b1, a, d, rd, er);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a,
                        input logic [31:0] exp, input logic exp_err);
    logic [31:0] rd; logic er;
    xfer(1'b0, a, 32'h0, rd, er);
    chk(req, rd, exp);
    chk({req, " err"}, {31'h0, er}, {31'h0, exp_err});
  endtask

  task automatic t_reset;
    rd_chk("R1 key reg locked", 12'h02C, 32'h0000AAAB, 1'b0);
    rd_chk("R1 first pin word zero", 12'h030, 32'h0, 1'b0);
    rd_chk("R1 last pin word zero", 12'hD1C, 32'h0, 1'b0);
    chk("R1 pin_coarse zero", {31'h0, |pin_coarse}, 32'h0);
    chk("R1 pin_fine zero", {31'h0, |pin_fine}, 32'h0);
  endtask

  task automatic t_cal;
    cal_refclk_period = 16'hFFFF; cal_coarse_delay = 16'h1111;
    cal_fine_ref = 16'h2222;
    rd_chk("R2 refclk word", 12'h014, 32'h00000A5C, 1'b0);
    rd_chk("R2 coarse word", 12'h018, 32'h01230456, 1'b0);
    rd_chk("R2 fine word", 12'h01C, 32'h07890ABC, 1'b0);
    wr32(12'h018, 32'hDEADBEEF);
    wr32(12'h014, 32'hFFFFFFFF);
    rd_chk("R2 coarse word after write", 12'h018, 32'h01230456, 1'b0);
    rd_chk("R2 refclk word after write", 12'h014, 32'h00000A5C, 1'b0);
  endtask

  task automatic t_closed_write;
    wr32(12'h030, mk(6'h29, 1'b0, 5'd7, 5'd19));
    rd_chk("R5 write while closed ignored", 12'h030, 32'h0, 1'b0);
    chk("R5 closed write no output", {27'h0, pin_coarse[4:0]}, 32'h0);
  endtask

  task automatic t_key;
    wr32(12'h02C, 32'h00001234);
    rd_chk("R3 other key no effect", 12'h02C, 32'h0000AAAB, 1'b0);
    wr32(12'h02C, 32'h0000AAAA);
    rd_chk("R3 open key", 12'h02C, 32'h0000AAAA, 1'b0);
    wr32(12'h02C, 32'h00005555);
    rd_chk("R3 other key keeps open", 12'h02C, 32'h0000AAAA, 1'b0);
  endtask

  task automatic t_pin_write;
    wr32(12'h030, mk(6'h29, 1'b0, 5'd7, 5'd19) | 32'h80000800);
    rd_chk("R4 pin0 word0 readback masked", 12'h030, mk(6'h29, 1'b0, 5'd7, 5'd19), 1'b0);
    chk("R7 pin0 coarse", {27'h0, pin_coarse[4:0]}, 32'd7);
    chk("R7 pin0 fine", {27'h0, pin_fine[4:0]}, 32'd19);
    wr32(12'h070, mk(6'h29, 1'b0, 5'd21, 5'd3));
    rd_chk("R4 pin5 word1 readback", 12'h070, mk(6'h29, 1'b0, 5'd21, 5'd3), 1'b0);
    chk("R7 word1 leaves pin5 coarse", {27'h0, pin_coarse[25 +: 5]}, 32'd0);
    wr32(12'hD1C, mk(6'h29, 1'b0, 5'd31, 5'd31));
    rd_chk("R4 last word readback", 12'hD1C, mk(6'h29, 1'b0, 5'd31, 5'd31), 1'b0);
    wr32(12'hD14, mk(6'h29, 1'b0, 5'd12, 5'd30));
    chk("R7 pin275 coarse", {27'h0, pin_coarse[275*5 +: 5]}, 32'd12);
    chk("R7 pin275 fine", {27'h0, pin_fine[275*5 +: 5]}, 32'd30);
  endtask

  task automatic t_bad_sig;
    wr32(12'h030, mk(6'h28, 1'b0, 5'd1, 5'd1));
    rd_chk("R5 bad signature ignored", 12'h030, mk(6'h29, 1'b0, 5'd7, 5'd19), 1'b0);
    chk("R5 bad signature output", {27'h0, pin_coarse[4:0]}, 32'd7);
  endtask

  task automatic t_lock_bit;
    wr32(12'h034, mk(6'h29, 1'b1, 5'd3, 5'd4));
    rd_chk("R6 locked word stored", 12'h034, mk(6'h29, 1'b1, 5'd3, 5'd4), 1'b0);
    wr32(12'h034, mk(6'h29, 1'b1, 5'd9, 5'd9));
    rd_chk("R6 locked rewrite ignored", 12'h034, mk(6'h29, 1'b1, 5'd3, 5'd4), 1'b0);
    wr32(12'h034, mk(6'h29, 1'b0, 5'd9, 5'd9));
    rd_chk("R6 unlock write accepted", 12'h034, mk(6'h29, 1'b0, 5'd9, 5'd9), 1'b0);
  endtask

  task automatic t_errors;
    logic [31:0] rd; logic er;
    rd_chk("R8 beyond last offset", 12'hD20, 32'h0, 1'b1);
    rd_chk("R8 misaligned read", 12'h031, 32'h0, 1'b1);
    xfer(1'b1, 12'h032, mk(6'h29, 1'b0, 5'd2, 5'd2), rd, er);
    chk("R8 misaligned write err", {31'h0, er}, 32'h1);
    rd_chk("R8 misaligned write no effect", 12'h030, mk(6'h29, 1'b0, 5'd7, 5'd19), 1'b0);
    xfer(1'b1, 12'hD20, 32'hFFFFFFFF, rd, er);
    chk("R8 out of range write err", {31'h0, er}, 32'h1);
    rd_chk("R8 reserved offset", 12'h000, 32'h0, 1'b0);
    rd_chk("R8 reserved offset 0x24", 12'h024, 32'h0, 1'b0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h018;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 first response valid", {31'h0, rsp_valid}, 32'h1);
    chk("R9 first response data", rsp_rdata, 32'h01230456);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held valid", {31'h0, rsp_valid}, 32'h1);
      chk("R9 held data", rsp_rdata, 32'h01230456);
      chk("R9 ready low while pending", {31'h0, req_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 response retired", {31'h0, rsp_valid}, 32'h0);
    chk("R9 ready back", {31'h0, req_ready}, 32'h1);
  endtask

  task automatic t_reclose;
    wr32(12'h02C, 32'h0000AAAB);
    rd_chk("R3 close key", 12'h02C, 32'h0000AAAB, 1'b0);
    wr32(12'h030, mk(6'h29, 1'b0, 5'd1, 5'd2));
    rd_chk("R5 write after reclose ignored", 12'h030, mk(6'h29, 1'b0, 5'd7, 5'd19), 1'b0);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cal();
    t_closed_write();
    t_key();
    t_pin_write();
    t_bad_sig();
    t_lock_bit();
    t_errors();
    t_backpressure();
    t_reclose();
    report();
    $finish;
  end

endmodule